// File: doc/BRIEF.md
# Indexed Voice Register File

This block is the host-side register window of a 32-voice wavetable synthesizer. The host first writes a voice number to one port and a function code to another; a 16-bit data window, reachable as a low-byte port and a high-byte port, then reads or writes the register that pair selects. Each voice owns fourteen 16-bit registers, held in a dense array. Function codes with bit 7 clear write a register, and the same code with bit 7 set reads it back.

Besides the per-voice words, the window reaches a few global registers: the active voice count, a 20-bit pointer into the card's sample memory, and a global control register whose bit 0 takes the synthesizer out of reset. A separate byte port moves single bytes to and from sample memory at the pointer. Byte accesses merge into one lane of the selected word, so that 8-bit and 16-bit hosts both work. The voice engine that consumes these registers lies outside this block.

Top module: `voice_regfile`

## Requirements
- R1: A write to port 2 loads the 8-bit voice select and a write to port 3 loads the 8-bit function select from data[7:0]; reading port 2 or 3 returns that register zero-extended to 16 bits.
- R2: With function select 0x00..0x0D, a write through port 4 or 5 stores into the word of voice select[4:0] and function select[3:0]; function select 0x80..0x8D reads that same word, and each voice/function pair holds its own word.
- R3: A byte write (word flag 0) to port 4 replaces only bits 7:0 of the target with data[7:0]; a byte write to port 5 replaces only bits 15:8 with data[7:0]; a word write (word flag 1) to port 4 or 5 replaces all 16 bits with data[15:0]. This also applies to function 0x43.
- R4: A byte read of a per-voice word returns bits 7:0 from port 4 and bits 15:8 from port 5 in data[7:0] with data[15:8] zero; a word read returns the whole word.
- R5: Per-voice writes leave the stored word unchanged while bit 0 of the control register is 0.
- R6: Function 0x0E writes data[7:0] into the voice count; function 0x8E reads it back as {0x00, count} on port 4 or 5; the count is also driven on voice_count_o.
- R7: A read of port 4 or 5 under any function select other than 0x80..0x8D and 0x8E returns 0xFFFF, and a read of ports 0, 1 or 6 returns 0xFFFF.
- R8: Function 0x43 writes bits 15:0 of the memory pointer with lane merging as in R3; function 0x44 sets bits 19:16 from data[3:0] and leaves bits 15:0; the pointer drives mem_addr_o.
- R9: A write to port 7 pulses mem_we_o in the same cycle with mem_wdata_o equal to data[7:0]; mem_we_o is 0 otherwise; a read of port 7 returns {0x00, mem_rdata_i}.
- R10: Function 0x4C writes data[7:0] to the control register; when data[0] is 0 the voice count is set to 0xCD and control bits 2 and 1 are cleared.
- R11: After rst_ni, the voice and function selects, control register, memory pointer and all per-voice words are 0 and the voice count is 0xCD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Host write strobe, one cycle per access |
| bus_port_i | input | 3 | Port offset of the access |
| bus_word_i | input | 1 | 1 for a 16-bit access, 0 for a byte access |
| bus_wdata_i | input | 16 | Host write data |
| bus_rdata_o | output | 16 | Read data for the port addressed, combinational |
| mem_addr_o | output | 20 | Sample memory pointer |
| mem_we_o | output | 1 | Sample memory byte write strobe |
| mem_wdata_o | output | 8 | Sample memory write byte |
| mem_rdata_i | input | 8 | Sample memory byte at mem_addr_o |
| voice_count_o | output | 8 | Active voice count |
| ctrl_o | output | 8 | Global control register |

## Verification
The bench builds the block at its default parameters: 32 voices, 14 functions per voice and a 20-bit pointer, which puts voice 31 and function 13, the last word of the array, within reach, along with voice selects whose upper three bits must be dropped. Its model keeps the words at a sparse voice*16+function index, unlike the dense array of the design, so an aliasing error between voices shows up as a mismatch. Memory read data is derived from the design's own pointer output, so port 7 reads also check the pointer. A long random phase mixes byte and word accesses, soft resets and unknown codes.

// File: rtl/voice_rf_pkg.sv
package voice_rf_pkg;
  localparam logic [2:0] PORT_VSEL = 3'd2;
  localparam logic [2:0] PORT_FSEL = 3'd3;
  localparam logic [2:0] PORT_DLO  = 3'd4;
  localparam logic [2:0] PORT_DHI  = 3'd5;
  localparam logic [2:0] PORT_MEM  = 3'd7;

  localparam logic [7:0] FN_CNT_WR  = 8'h0E;
  localparam logic [7:0] FN_CNT_RD  = 8'h8E;
  localparam logic [7:0] FN_ADDR_LO = 8'h43;
  localparam logic [7:0] FN_ADDR_HI = 8'h44;
  localparam logic [7:0] FN_CTRL    = 8'h4C;
  localparam logic [7:0] CTRL_SOFT_MASK = 8'hF9;

  typedef struct packed {
    logic word;
    logic hi;
  } lane_t;
endpackage

// File: rtl/lane_merge.sv
module lane_merge
  import voice_rf_pkg::*;
(
  input  logic [15:0] old_i,
  input  logic [15:0] wdata_i,
  input  lane_t       lane_i,
  output logic [15:0] merged_o
);
  always_comb begin
    if (lane_i.word)    merged_o = wdata_i;
    else if (lane_i.hi) merged_o = {wdata_i[7:0], old_i[7:0]};
    else                merged_o = {old_i[15:8], wdata_i[7:0]};
  end
endmodule

// File: rtl/voice_word_array.sv
module voice_word_array #(
  parameter int NUM_VOICES = 32,
  parameter int NUM_FUNCS  = 14
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [$clog2(NUM_VOICES)-1:0] voice_i,
  input  logic [3:0]                    func_i,
  input  logic [15:0]                   wdata_i,
  output logic [15:0]                   rdata_o
);
  localparam int VW    = $clog2(NUM_VOICES);
  localparam int DEPTH = NUM_VOICES * NUM_FUNCS;
  localparam int IW    = $clog2(DEPTH) + 1;

  logic [IW-1:0] idx;
  logic [15:0]   mem_q [DEPTH];

  // dense layout: no unused slots for codes above NUM_FUNCS-1
  assign idx = IW'(voice_i) * IW'(NUM_FUNCS) + IW'(func_i);

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            mem_q[g] <= '0;
      else if (we_i && (idx == IW'(g)))       mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = (idx < IW'(DEPTH)) ? mem_q[idx] : '0;

  logic unused_vw;
  assign unused_vw = ^VW;
endmodule

// File: rtl/mem_pointer.sv
module mem_pointer
  import voice_rf_pkg::*;
#(
  parameter int MEM_AW = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_lo_i,
  input  logic              we_hi_i,
  input  lane_t             lane_i,
  input  logic [15:0]       wdata_i,
  output logic [MEM_AW-1:0] addr_o
);
  localparam int HI_W = MEM_AW - 16;

  logic [15:0]     lo_q, lo_next;
  logic [HI_W-1:0] hi_q;

  lane_merge i_merge (
    .old_i   (lo_q),
    .wdata_i (wdata_i),
    .lane_i  (lane_i),
    .merged_o(lo_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (we_lo_i) lo_q <= lo_next;
      if (we_hi_i) hi_q <= wdata_i[HI_W-1:0];
    end
  end

  assign addr_o = {hi_q, lo_q};
endmodule

// File: rtl/voice_regfile.sv
module voice_regfile
  import voice_rf_pkg::*;
#(
  parameter int         NUM_VOICES = 32,
  parameter int         NUM_FUNCS  = 14,
  parameter int         MEM_AW     = 20,
  parameter logic [7:0] COUNT_RST  = 8'hCD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [2:0]        bus_port_i,
  input  logic              bus_word_i,
  input  logic [15:0]       bus_wdata_i,
  output logic [15:0]       bus_rdata_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  output logic [7:0]        voice_count_o,
  output logic [7:0]        ctrl_o
);
  localparam int VW = $clog2(NUM_VOICES);

  logic [7:0]  vsel_q, fsel_q, cnt_q, ctrl_q;
  logic        data_port, data_we;
  logic        fn_voice_wr, fn_voice_rd, func_ok;
  logic        voice_we;
  lane_t       lane;
  logic [15:0] voice_word, voice_merged;

  assign data_port = (bus_port_i == PORT_DLO) || (bus_port_i == PORT_DHI);
  assign data_we   = bus_we_i && data_port;
  assign lane      = '{word: bus_word_i, hi: (bus_port_i == PORT_DHI)};

  assign func_ok     = {1'b0, fsel_q[3:0]} < 5'(NUM_FUNCS);
  assign fn_voice_wr = (fsel_q[7:4] == 4'h0) && func_ok;
  assign fn_voice_rd = (fsel_q[7:4] == 4'h8) && func_ok;
  assign voice_we    = data_we && fn_voice_wr && ctrl_q[0];

  // selects
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vsel_q <= '0;
      fsel_q <= '0;
    end else if (bus_we_i) begin
      if (bus_port_i == PORT_VSEL) vsel_q <= bus_wdata_i[7:0];
      if (bus_port_i == PORT_FSEL) fsel_q <= bus_wdata_i[7:0];
    end
  end

  // voice count and control; a control write with bit0 low is a soft reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= COUNT_RST;
      ctrl_q <= '0;
    end else if (data_we) begin
      if (fsel_q == FN_CNT_WR) cnt_q <= bus_wdata_i[7:0];
      if (fsel_q == FN_CTRL) begin
        if (bus_wdata_i[0]) begin
          ctrl_q <= bus_wdata_i[7:0];
        end else begin
          ctrl_q <= bus_wdata_i[7:0] & CTRL_SOFT_MASK;
          cnt_q  <= COUNT_RST;
        end
      end
    end
  end

  lane_merge i_voice_merge (
    .old_i   (voice_word),
    .wdata_i (bus_wdata_i),
    .lane_i  (lane),
    .merged_o(voice_merged)
  );

  voice_word_array #(
    .NUM_VOICES(NUM_VOICES),
    .NUM_FUNCS (NUM_FUNCS)
  ) i_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (voice_we),
    .voice_i(vsel_q[VW-1:0]),
    .func_i (fsel_q[3:0]),
    .wdata_i(voice_merged),
    .rdata_o(voice_word)
  );

  mem_pointer #(.MEM_AW(MEM_AW)) i_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_lo_i(data_we && (fsel_q == FN_ADDR_LO)),
    .we_hi_i(data_we && (fsel_q == FN_ADDR_HI)),
    .lane_i (lane),
    .wdata_i(bus_wdata_i),
    .addr_o (mem_addr_o)
  );

  always_comb begin
    bus_rdata_o = 16'hFFFF;
    case (bus_port_i)
      PORT_VSEL: bus_rdata_o = {8'h00, vsel_q};
      PORT_FSEL: bus_rdata_o = {8'h00, fsel_q};
      PORT_DLO, PORT_DHI: begin
        if (fn_voice_rd) begin
          if (lane.word)    bus_rdata_o = voice_word;
          else if (lane.hi) bus_rdata_o = {8'h00, voice_word[15:8]};
          else              bus_rdata_o = {8'h00, voice_word[7:0]};
        end else if (fsel_q == FN_CNT_RD) begin
          bus_rdata_o = {8'h00, cnt_q};
        end
      end
      PORT_MEM:  bus_rdata_o = {8'h00, mem_rdata_i};
      default:   bus_rdata_o = 16'hFFFF;
    endcase
  end

  assign mem_we_o      = bus_we_i && (bus_port_i == PORT_MEM);
  assign mem_wdata_o   = bus_wdata_i[7:0];
  assign voice_count_o = cnt_q;
  assign ctrl_o        = ctrl_q;
endmodule

// File: rtl/voice_regfile_chk.sv
module voice_regfile_chk #(
  parameter int MEM_AW = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [2:0]        bus_port_i,
  input logic              bus_word_i,
  input logic [15:0]       bus_wdata_i,
  input logic [15:0]       bus_rdata_o,
  input logic [MEM_AW-1:0] mem_addr_o,
  input logic              mem_we_o,
  input logic [7:0]        voice_count_o,
  input logic [7:0]        ctrl_o,
  input logic [7:0]        fsel_i
);
  logic dwe;
  assign dwe = bus_we_i && ((bus_port_i == 3'd4) || (bus_port_i == 3'd5));

  AST_SOFT_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dwe && (fsel_i == 8'h4C) && !bus_wdata_i[0]
    |=> (voice_count_o == 8'hCD) && (ctrl_o[2:1] == 2'b00)); // R10

  AST_PTR_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i && (bus_port_i == 3'd4) && (fsel_i == 8'h44)
    |=> (mem_addr_o[MEM_AW-1:16] == $past(bus_wdata_i[MEM_AW-17:0]))
        && $stable(mem_addr_o[15:0])); // R8

  AST_PTR_HI_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i && !bus_word_i && (bus_port_i == 3'd5) && (fsel_i == 8'h43)
    |=> $stable(mem_addr_o[7:0])); // R3

  AST_UNKNOWN_FN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_port_i == 3'd4) && (fsel_i == 8'h8F) |-> bus_rdata_o == 16'hFFFF); // R7

  AST_MEM_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> bus_we_i && (bus_port_i == 3'd7)); // R9

  AST_COUNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dwe && ((fsel_i == 8'h0E) || (fsel_i == 8'h4C))) |=> $stable(voice_count_o)); // R6

  AST_SEL_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_port_i == 3'd2) || (bus_port_i == 3'd3) |-> bus_rdata_o[15:8] == 8'h00); // R1
endmodule

bind voice_regfile voice_regfile_chk #(.MEM_AW(MEM_AW)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_we_i     (bus_we_i),
  .bus_port_i   (bus_port_i),
  .bus_word_i   (bus_word_i),
  .bus_wdata_i  (bus_wdata_i),
  .bus_rdata_o  (bus_rdata_o),
  .mem_addr_o   (mem_addr_o),
  .mem_we_o     (mem_we_o),
  .voice_count_o(voice_count_o),
  .ctrl_o       (ctrl_o),
  .fsel_i       (fsel_q)
);

// File: tb/test_voice_regfile.sv
`timescale 1ns/1ps
module test_voice_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  port = 3'd0;
  logic        word = 1'b0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic [19:0] maddr;
  logic        mwe;
  logic [7:0]  mwdata, mrdata, vcount, ctrl;

  int n_cmp = 0;
  int n_bad = 0;

  // model state
  logic [15:0] m_vmem [0:511];
  logic [7:0]  m_vsel, m_fsel, m_cnt, m_ctrl;
  logic [19:0] m_addr;

  always #2 clk = ~clk;

  function automatic logic [7:0] mem_fn(input logic [19:0] a);
    return a[7:0] ^ a[19:12] ^ 8'h5A;
  endfunction

  assign mrdata = mem_fn(maddr);

  voice_regfile i_voice_regfile (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_port_i(port),
    .bus_word_i(word), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .mem_addr_o(maddr), .mem_we_o(mwe), .mem_wdata_o(mwdata),
    .mem_rdata_i(mrdata), .voice_count_o(vcount), .ctrl_o(ctrl)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [2:0] p,
                                        input logic w, input logic [15:0] d);
    if (w) return d;
    if (p == 3'd5) return {d[7:0], old[7:0]};
    return {old[15:8], d[7:0]};
  endfunction

  function automatic int vidx();
    return int'(m_vsel % 32) * 16 + int'(m_fsel[3:0]);
  endfunction

  task automatic model_init();
    for (int i = 0; i < 512; i++) m_vmem[i] = 16'h0;
    m_vsel = 0; m_fsel = 0; m_cnt = 8'hCD; m_ctrl = 0; m_addr = 0;
  endtask

  task automatic expect_read(output logic [15:0] v, output string tag);
    logic [15:0] w;
    v = 16'hFFFF; tag = "R7";
    case (port)
      3'd2: begin v = {8'h0, m_vsel}; tag = "R1"; end
      3'd3: begin v = {8'h0, m_fsel}; tag = "R1"; end
      3'd4, 3'd5: begin
        if (m_fsel >= 8'h80 && m_fsel <= 8'h8D) begin
          w = m_vmem[vidx()];
          if (word) begin v = w; tag = "R2"; end
          else begin v = (port == 3'd5) ? {8'h0, w[15:8]} : {8'h0, w[7:0]}; tag = "R4"; end
        end else if (m_fsel == 8'h8E) begin v = {8'h0, m_cnt}; tag = "R6"; end
      end
      3'd7: begin v = {8'h0, mem_fn(m_addr)}; tag = "R9"; end
      default: ;
    endcase
  endtask

  task automatic model_step();
    if (!we) return;
    case (port)
      3'd2: m_vsel = wdata[7:0];
      3'd3: m_fsel = wdata[7:0];
      3'd4, 3'd5: begin
        if (m_fsel <= 8'h0D) begin
          if (m_ctrl[0]) m_vmem[vidx()] = merge(m_vmem[vidx()], port, word, wdata);
        end else if (m_fsel == 8'h0E) m_cnt = wdata[7:0];
        else if (m_fsel == 8'h43) m_addr[15:0] = merge(m_addr[15:0], port, word, wdata);
        else if (m_fsel == 8'h44) m_addr[19:16] = wdata[3:0];
        else if (m_fsel == 8'h4C) begin
          m_ctrl = wdata[7:0];
          if (!wdata[0]) begin m_cnt = 8'hCD; m_ctrl = m_ctrl & 8'hF9; end
        end
      end
      default: ;
    endcase
  endtask

  // one bus cycle: drive, compare all outputs, advance model
  task automatic cyc(input logic w_e, input logic [2:0] p, input logic w_d, input logic [15:0] d);
    logic [15:0] ev;
    string tag;
    @(negedge clk);
    we = w_e; port = p; word = w_d; wdata = d;
    #1;
    expect_read(ev, tag);
    chk({tag, " read data"}, {16'h0, rdata}, {16'h0, ev});
    chk("R9 mem_we", {31'h0, mwe}, {31'h0, w_e && p == 3'd7});
    if (w_e && p == 3'd7) chk("R9 mem_wdata", {24'h0, mwdata}, {24'h0, d[7:0]});
    chk("R10 ctrl", {24'h0, ctrl}, {24'h0, m_ctrl});
    chk("R6 count", {24'h0, vcount}, {24'h0, m_cnt});
    chk("R8 pointer", {12'h0, maddr}, {12'h0, m_addr});
    model_step();
  endtask

  task automatic wr(input logic [2:0] p, input logic w_d, input logic [15:0] d);
    cyc(1'b1, p, w_d, d);
  endtask

  task automatic rd(input logic [2:0] p, input logic w_d);
    cyc(1'b0, p, w_d, 16'h0);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    model_init();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R11: reset state
    #1;
    chk("R11 count", {24'h0, vcount}, 32'hCD);
    chk("R11 ctrl", {24'h0, ctrl}, 32'h0);
    chk("R11 pointer", {12'h0, maddr}, 32'h0);
    rd(3'd2, 1'b1);                       // R1 vsel 0
    rd(3'd4, 1'b1);                       // R7: fsel 0 not readable
    wr(3'd3, 1'b1, 16'h0080); rd(3'd4, 1'b1);  // R11 word zero
    // R5: writes gated while ctrl bit0 = 0
    wr(3'd2, 1'b1, 16'h0003); wr(3'd3, 1'b1, 16'h0005);
    wr(3'd4, 1'b1, 16'hBEEF);
    wr(3'd3, 1'b1, 16'h0085); rd(3'd4, 1'b1);
    // R10: enable
    wr(3'd3, 1'b1, 16'h004C); wr(3'd4, 1'b1, 16'h0007);
    // R2: word writes at several indices, including last word
    wr(3'd3, 1'b1, 16'h0005); wr(3'd4, 1'b1, 16'hBEEF);
    wr(3'd2, 1'b1, 16'h001F); wr(3'd3, 1'b1, 16'h000D); wr(3'd5, 1'b1, 16'hA55A);
    wr(3'd2, 1'b1, 16'h00E3); wr(3'd3, 1'b1, 16'h0006); wr(3'd4, 1'b1, 16'h1234);
    wr(3'd3, 1'b1, 16'h0085); rd(3'd4, 1'b1);  // voice 3 fn 5
    wr(3'd3, 1'b1, 16'h0086); rd(3'd4, 1'b1);
    wr(3'd2, 1'b1, 16'h001F); wr(3'd3, 1'b1, 16'h008D); rd(3'd4, 1'b1);
    // R3: byte lanes
    wr(3'd3, 1'b1, 16'h000D); wr(3'd4, 1'b0, 16'hFF11); wr(3'd5, 1'b0, 16'hEE22);
    wr(3'd3, 1'b1, 16'h008D); rd(3'd4, 1'b1);
    rd(3'd4, 1'b0); rd(3'd5, 1'b0);       // R4
    // R6 count
    wr(3'd3, 1'b1, 16'h000E); wr(3'd4, 1'b0, 16'h0018);
    wr(3'd3, 1'b1, 16'h008E); rd(3'd4, 1'b1); rd(3'd5, 1'b0);
    // R7 unknown
    wr(3'd3, 1'b1, 16'h008F); rd(3'd4, 1'b1);
    wr(3'd3, 1'b1, 16'h0045); rd(3'd5, 1'b0);
    rd(3'd0, 1'b1); rd(3'd6, 1'b0);
    // R8 pointer and R9 memory port
    wr(3'd3, 1'b1, 16'h0043); wr(3'd4, 1'b1, 16'hC0DE); wr(3'd5, 1'b0, 16'h0077);
    wr(3'd3, 1'b1, 16'h0044); wr(3'd4, 1'b1, 16'hFFF9);
    rd(3'd7, 1'b0); wr(3'd7, 1'b0, 16'h00AB);
    // R10 soft reset
    wr(3'd3, 1'b1, 16'h004C); wr(3'd4, 1'b0, 16'h00FE);
    wr(3'd3, 1'b1, 16'h0000); wr(3'd4, 1'b1, 16'h9999);  // gated again (R5)
    wr(3'd3, 1'b1, 16'h0080); rd(3'd4, 1'b1);
    wr(3'd3, 1'b1, 16'h004C); wr(3'd4, 1'b0, 16'h0003);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      r = $urandom;
      case (r[2:0])
        3'd0: wr(3'd2, 1'b1, {8'h0, r[15:8]});
        3'd1: begin
          case (r[10:8])
            3'd0, 3'd1: wr(3'd3, 1'b1, {12'h0, r[15:12]});
            3'd2, 3'd3: wr(3'd3, 1'b1, {12'h8, r[15:12]});
            3'd4: wr(3'd3, 1'b1, r[11] ? 16'h0043 : 16'h0044);
            3'd5: wr(3'd3, 1'b1, r[11] ? 16'h004C : 16'h008F);
            default: wr(3'd3, 1'b1, r[11] ? 16'h000E : 16'h008E);
          endcase
        end
        3'd2, 3'd3: begin
          if (m_fsel == 8'h4C && r[31:29] != 3'd0) wr(r[3] ? 3'd5 : 3'd4, r[4], r[31:16] | 16'h1);
          else wr(r[3] ? 3'd5 : 3'd4, r[4], r[31:16]);
        end
        3'd4, 3'd5: rd(r[3] ? 3'd5 : 3'd4, r[4]);
        3'd6: cyc(r[5], 3'd7, 1'b0, r[31:16]);
        default: rd(r[10:8], r[4]);
      endcase
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule